// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Front End

This block holds the software-visible control state of one bus-master DMA channel for a disk-style controller. It keeps a command byte, a status byte and a 32-bit descriptor table base address. These sit behind a small byte-addressed register port that takes 1-, 2- and 4-byte accesses. Software writes the start bit, and the block turns a change of that bit into a start or abort pulse for a separate descriptor-walking engine. When the channel starts, the block also loads the engine's current table pointer from the base register.

The engine is seen only through a few signals. It reports a transfer in flight (`eng_busy_i`) and the end of a transfer (`eng_done_i`, with `eng_more_i` set when more data is still pending). A stop request never cuts a transfer partway: the active flag drops only after the engine has drained. The device interrupt line passes straight through to the output. Its rising edge is also latched into a status bit, and software clears that bit by writing 1 to it.

The register port has byte lanes 0 to 7. Lane 0 holds the command, lane 2 holds the status, and lanes 4 to 7 hold the base address, least significant byte first. Lanes 1 and 3 read as zero and ignore writes.

Top module: `dma_ctl_regs`

## Requirements
- R1: A write that covers lane 0 starts or stops the channel only when bit 0 of the written byte differs from the stored start bit. Writing the same start value again produces no start pulse, no abort pulse and no change to the active flag.
- R2: On a 0-to-1 change of the start bit, `cur_ptr_o` is loaded with the base address one cycle later. If the active flag was clear, it becomes set and `eng_start_o` pulses for exactly one cycle. If it was already set, no start pulse is produced.
- R3: On a 1-to-0 change of the start bit, the active flag clears as soon as `eng_busy_i` is low, and `eng_abort_o` pulses for one cycle if the flag was set. While `eng_busy_i` stays high the flag stays set. A new 0-to-1 change before draining cancels the pending stop.
- R4: The command byte stores only bit 0 (start) and bit 3 (direction, also driven on `dir_o`). The other bits read back as zero.
- R5: `irq_o` always equals `dev_irq_i`. A rising edge of `dev_irq_i` sets status bit 2 on the next clock, and a steady or low level leaves it unchanged. Writing 1 to status bit 2 clears it. Status bit 0 mirrors the active flag and is read-only.
- R6: A write updates exactly the lanes in the range offset to offset+n-1, where n is 1, 2 or 4 for `acc_size_i` 0, 1 or 2 (and 4 for 3). Lane k of the write takes byte k-offset of `acc_wdata_i`. Base address bits 1:0 always stay zero.
- R7: `acc_rdata_o` is combinational. It equals the 8-lane register image shifted right by 8×offset, masked to n bytes.
- R8: A synchronous active-low reset clears the command, status, base address, current pointer, pending stop and active flag, and also suppresses any start or abort pulse.
- R9: When `eng_done_i` is high with the active flag set, the flag clears if `eng_more_i` is low and stays set if `eng_more_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_wr_i | input | 1 | Register write strobe |
| acc_off_i | input | 3 | Byte offset of the access |
| acc_size_i | input | 2 | Access width code: 0=1, 1=2, 2 or 3=4 bytes |
| acc_wdata_i | input | 32 | Write data, byte 0 at the offset lane |
| acc_rdata_o | output | 32 | Read data for the offset and width given |
| eng_busy_i | input | 1 | Engine has a transfer in flight |
| eng_done_i | input | 1 | Engine finished a transfer |
| eng_more_i | input | 1 | Qualifies done: more data is pending |
| eng_start_o | output | 1 | One-cycle start pulse to the engine |
| eng_abort_o | output | 1 | One-cycle abort pulse after a stop has drained |
| active_o | output | 1 | Channel active flag |
| dir_o | output | 1 | Stored direction bit |
| cur_ptr_o | output | 32 | Current descriptor table pointer |
| dev_irq_i | input | 1 | Interrupt request from the device |
| irq_o | output | 1 | Forwarded interrupt line |

## Verification
The assertions assume the engine raises `eng_done_i` only while the channel is active. They also assume that a start is never written in the same cycle that a stop drains or a last-done arrives. The bench keeps to both assumptions: it drives the engine signals only when nothing is written to lane 0, and it moves `eng_busy_i` only between writes. Base writes and reads are swept over every offset and width. The command byte is swept over all 256 values with the engine idle. The drain, done and interrupt cases are then driven one at a time.

// File: rtl/dma_ctl_pkg.sv
// Package: lane layout and access-width decoding shared by the
// register front end. Assumes an 8-lane byte-addressed register window.
package dma_ctl_pkg;
    localparam int LANE_CMD  = 0;
    localparam int LANE_STAT = 2;
    localparam int LANE_BASE = 4;

    localparam int CMD_START_BIT = 0;
    localparam int CMD_DIR_BIT   = 3;
    localparam int STAT_ACT_BIT  = 0;
    localparam int STAT_IRQ_BIT  = 2;

    typedef enum logic [1:0] {
        ACC_B1 = 2'd0,
        ACC_B2 = 2'd1,
        ACC_B4 = 2'd2,
        ACC_BX = 2'd3
    } acc_size_e;

    // Number of bytes touched by an access width code.
    function automatic int size_bytes(input logic [1:0] code);
        case (acc_size_e'(code))
            ACC_B1:  return 1;
            ACC_B2:  return 2;
            default: return 4;
        endcase
    endfunction
endpackage

// File: rtl/dma_ctl_base.sv
// Base address register: per-byte lane writes, low two bits forced to zero.
// Assumes the lane enables and lane data were already aligned by the top.
module dma_ctl_base #(
    parameter int PTR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PTR_W/8-1:0]   lane_we_i,
    input  logic [PTR_W-1:0]     lane_data_i,
    output logic [PTR_W-1:0]     base_o
);
    localparam int NB = PTR_W / 8;

    logic [PTR_W-1:0] base_q;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        // Per-byte update of the base address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[8*b +: 8] <= 8'h00;
            end else if (lane_we_i[b]) begin
                if (b == 0) base_q[8*b +: 8] <= {lane_data_i[8*b+2 +: 6], 2'b00};
                else        base_q[8*b +: 8] <= lane_data_i[8*b +: 8];
            end
        end
    end

    assign base_o = base_q;

    p_base_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we_i == '0) |=> $stable(base_q));
endmodule

// File: rtl/dma_ctl_cmd.sv
// Command and activity control: start-bit edge detection, pointer reload,
// drained stop and engine completion. Assumes engine done only while active.
module dma_ctl_cmd #(
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we_i,
    input  logic             start_bit_i,
    input  logic             dir_bit_i,
    input  logic [PTR_W-1:0] base_i,
    input  logic             eng_busy_i,
    input  logic             eng_done_i,
    input  logic             eng_more_i,
    output logic             start_q_o,
    output logic             dir_q_o,
    output logic             active_o,
    output logic             eng_start_o,
    output logic             eng_abort_o,
    output logic [PTR_W-1:0] cur_ptr_o
);
    logic             start_q, dir_q, active_q, stop_pend_q;
    logic             start_p_q, abort_p_q;
    logic [PTR_W-1:0] cur_ptr_q;
    logic             rise_w, fall_w;

    // Start-bit change detection for the current write.
    always_comb begin
        rise_w = cmd_we_i &&  start_bit_i && !start_q;
        fall_w = cmd_we_i && !start_bit_i &&  start_q;
    end

    // Control state update: completion, drained stop, then command write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q     <= 1'b0;
            dir_q       <= 1'b0;
            active_q    <= 1'b0;
            stop_pend_q <= 1'b0;
            start_p_q   <= 1'b0;
            abort_p_q   <= 1'b0;
            cur_ptr_q   <= '0;
        end else begin
            start_p_q <= 1'b0;
            abort_p_q <= 1'b0;
            if (eng_done_i && active_q && !eng_more_i) begin
                active_q <= 1'b0;
            end
            if (stop_pend_q && !eng_busy_i) begin
                active_q    <= 1'b0;
                stop_pend_q <= 1'b0;
                abort_p_q   <= active_q;
            end
            if (cmd_we_i) begin
                start_q <= start_bit_i;
                dir_q   <= dir_bit_i;
            end
            if (rise_w) begin
                cur_ptr_q   <= base_i;
                stop_pend_q <= 1'b0;
                if (!active_q) begin
                    active_q  <= 1'b1;
                    start_p_q <= 1'b1;
                end
            end else if (fall_w) begin
                if (eng_busy_i) begin
                    stop_pend_q <= 1'b1;
                end else begin
                    active_q  <= 1'b0;
                    abort_p_q <= active_q;
                end
            end
        end
    end

    assign start_q_o   = start_q;
    assign dir_q_o     = dir_q;
    assign active_o    = active_q;
    assign eng_start_o = start_p_q;
    assign eng_abort_o = abort_p_q;
    assign cur_ptr_o   = cur_ptr_q;

    p_start_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start_o |-> $past(cmd_we_i && start_bit_i && !start_q));
    p_start_sets_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start_o |-> active_q);
    p_ptr_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we_i && start_bit_i && !start_q) |=> (cur_ptr_q == $past(base_i)));
    p_hold_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && eng_busy_i && !(eng_done_i && !eng_more_i)) |=> active_q);
    p_abort_drained_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort_o |-> (!active_q && !$past(eng_busy_i)));
    p_done_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done_i && !eng_more_i && active_q && !cmd_we_i) |=> !active_q);
endmodule

// File: rtl/dma_ctl_irq.sv
// Interrupt status: passes the device line through and latches its rising
// edge into a write-one-to-clear status bit. A set wins over a clear.
module dma_ctl_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic dev_irq_i,
    input  logic clr_we_i,
    input  logic clr_bit_i,
    output logic stat_o,
    output logic irq_o
);
    logic prev_q, stat_q;

    // Edge history and latched status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            prev_q <= dev_irq_i;
            if (dev_irq_i && !prev_q)     stat_q <= 1'b1;
            else if (clr_we_i && clr_bit_i) stat_q <= 1'b0;
        end
    end

    assign stat_o = stat_q;
    assign irq_o  = dev_irq_i;

    p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_irq_i) |=> stat_q);
    p_irq_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && clr_bit_i && !(dev_irq_i && !prev_q)) |=> !stat_q);
    p_irq_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(clr_we_i && clr_bit_i) && !(dev_irq_i && !prev_q)) |=> $stable(stat_q));
endmodule

// File: rtl/dma_ctl_regs.sv
// Register front end of a bus-master DMA channel. Decodes byte-lane accesses
// onto command, status and base registers and builds the read image.
// Assumes accesses never need a wait state; reads have no side effects.
module dma_ctl_regs
    import dma_ctl_pkg::*;
#(
    parameter int PTR_W = 32,
    parameter int OFF_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_wr_i,
    input  logic [OFF_W-1:0] acc_off_i,
    input  logic [1:0]       acc_size_i,
    input  logic [31:0]      acc_wdata_i,
    output logic [31:0]      acc_rdata_o,
    input  logic             eng_busy_i,
    input  logic             eng_done_i,
    input  logic             eng_more_i,
    output logic             eng_start_o,
    output logic             eng_abort_o,
    output logic             active_o,
    output logic             dir_o,
    output logic [PTR_W-1:0] cur_ptr_o,
    input  logic             dev_irq_i,
    output logic             irq_o
);
    localparam int NLANE = 2 ** OFF_W;
    localparam int NB    = PTR_W / 8;
    localparam int IMG_W = 8 * NLANE;

    logic [NLANE-1:0]   lane_hit;
    logic [7:0]         lane_byte [NLANE];
    logic [PTR_W-1:0]   base_w;
    logic [NB-1:0]      base_we;
    logic [PTR_W-1:0]   base_data;
    logic               start_q, dir_q, act_w, irq_stat;
    logic [7:0]         cmd_rd, stat_rd;
    logic [IMG_W-1:0]   img, img_sh;
    logic [31:0]        rd_mask;

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        // Lane selection and byte extraction for this lane.
        always_comb begin
            int rel;
            logic [31:0] sh;
            rel = l - int'(acc_off_i);
            lane_hit[l]  = acc_wr_i && (rel >= 0) && (rel < size_bytes(acc_size_i));
            sh           = (rel >= 0 && rel < 4) ? (acc_wdata_i >> (8 * rel)) : 32'h0;
            lane_byte[l] = sh[7:0];
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_base_lane
        assign base_we[b]          = lane_hit[LANE_BASE + b];
        assign base_data[8*b +: 8] = lane_byte[LANE_BASE + b];
    end

    dma_ctl_base #(.PTR_W(PTR_W)) base_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .lane_we_i   (base_we),
        .lane_data_i (base_data),
        .base_o      (base_w)
    );

    dma_ctl_cmd #(.PTR_W(PTR_W)) cmd_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_we_i    (lane_hit[LANE_CMD]),
        .start_bit_i (lane_byte[LANE_CMD][CMD_START_BIT]),
        .dir_bit_i   (lane_byte[LANE_CMD][CMD_DIR_BIT]),
        .base_i      (base_w),
        .eng_busy_i  (eng_busy_i),
        .eng_done_i  (eng_done_i),
        .eng_more_i  (eng_more_i),
        .start_q_o   (start_q),
        .dir_q_o     (dir_q),
        .active_o    (act_w),
        .eng_start_o (eng_start_o),
        .eng_abort_o (eng_abort_o),
        .cur_ptr_o   (cur_ptr_o)
    );

    dma_ctl_irq irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_irq_i (dev_irq_i),
        .clr_we_i  (lane_hit[LANE_STAT]),
        .clr_bit_i (lane_byte[LANE_STAT][STAT_IRQ_BIT]),
        .stat_o    (irq_stat),
        .irq_o     (irq_o)
    );

    // Read image assembly and width-masked shift.
    always_comb begin
        cmd_rd                   = 8'h00;
        cmd_rd[CMD_START_BIT]    = start_q;
        cmd_rd[CMD_DIR_BIT]      = dir_q;
        stat_rd                  = 8'h00;
        stat_rd[STAT_ACT_BIT]    = act_w;
        stat_rd[STAT_IRQ_BIT]    = irq_stat;
        img                      = '0;
        img[8*LANE_CMD  +: 8]    = cmd_rd;
        img[8*LANE_STAT +: 8]    = stat_rd;
        img[8*LANE_BASE +: PTR_W] = base_w;
        img_sh                   = img >> (8 * int'(acc_off_i));
        case (acc_size_e'(acc_size_i))
            ACC_B1:  rd_mask = 32'h0000_00FF;
            ACC_B2:  rd_mask = 32'h0000_FFFF;
            default: rd_mask = 32'hFFFF_FFFF;
        endcase
        acc_rdata_o = img_sh[31:0] & rd_mask;
    end

    assign active_o = act_w;
    assign dir_o    = dir_q;

    p_same_start_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_hit[LANE_CMD] && (lane_byte[LANE_CMD][CMD_START_BIT] == start_q)
         && !eng_done_i && !eng_busy_i && !start_q) |=> !eng_start_o && !eng_abort_o);
endmodule

// File: tb/dma_ctl_regs_tb_top.sv
module dma_ctl_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_wr = 1'b0;
    logic [2:0]  acc_off = 3'd0;
    logic [1:0]  acc_size = 2'd0;
    logic [31:0] acc_wdata = 32'h0;
    logic [31:0] acc_rdata;
    logic        eng_busy = 1'b0, eng_done = 1'b0, eng_more = 1'b0;
    logic        eng_start, eng_abort, active, dir;
    logic [31:0] cur_ptr;
    logic        dev_irq = 1'b0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    logic saw_start, saw_abort;
    logic [31:0] base_m;
    logic [7:0]  cmd_m, stat_m;
    logic        act_m;

    always #2 clk = ~clk;

    dma_ctl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .acc_wr_i(acc_wr), .acc_off_i(acc_off),
        .acc_size_i(acc_size), .acc_wdata_i(acc_wdata), .acc_rdata_o(acc_rdata),
        .eng_busy_i(eng_busy), .eng_done_i(eng_done), .eng_more_i(eng_more),
        .eng_start_o(eng_start), .eng_abort_o(eng_abort), .active_o(active),
        .dir_o(dir), .cur_ptr_o(cur_ptr), .dev_irq_i(dev_irq), .irq_o(irq_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int off, input int sz, input logic [31:0] d);
        @(negedge clk);
        acc_wr = 1'b1; acc_off = off[2:0]; acc_size = sz[1:0]; acc_wdata = d;
        @(posedge clk);
        #1;
        saw_start = eng_start; saw_abort = eng_abort;
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    task automatic rd(input int off, input int sz, output logic [31:0] d);
        @(negedge clk);
        acc_off = off[2:0]; acc_size = sz[1:0];
        #1;
        d = acc_rdata;
    endtask

    function automatic int nbytes(input int sz);
        return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] mask_of(input int sz);
        return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] img_read(input int off, input int sz);
        logic [63:0] img;
        img = {base_m, 8'h00, stat_m, 8'h00, cmd_m};
        img = img >> (8 * off);
        return img[31:0] & mask_of(sz);
    endfunction

    task automatic pulse_done(input logic more);
        @(negedge clk); eng_done = 1'b1; eng_more = more;
        @(negedge clk); eng_done = 1'b0; eng_more = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [31:0] d;
        logic        s_m, exp_st, exp_ab;
        base_m = 0; cmd_m = 0; stat_m = 0; act_m = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset start pulse", eng_start, 0);
        check("R8 reset active", active, 0);
        rd(0, 2, d); check("R8 reset cmd/status", d, 32'h0);
        rd(4, 2, d); check("R8 reset base", d, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R6/R7 sweep over all base offsets and widths.
        for (int off = 0; off < 4; off++) begin
            for (int sz = 0; sz < 3; sz++) begin
                logic [31:0] pat;
                logic [63:0] mk, dt;
                pat = 32'hA5C3_9E17 ^ (off * 32'h0101_0101) ^ (sz * 32'h1357_2468);
                wr(4 + off, sz, pat);
                mk = {32'h0, mask_of(sz)} << (8 * off);
                dt = ({32'h0, pat & mask_of(sz)} << (8 * off));
                base_m = (base_m & ~mk[31:0]) | (dt[31:0] & 32'hFFFF_FFFC);
                rd(4, 2, d); check("R6 base lane write", d, base_m);
                rd(4 + off, sz, d); check("R7 base read shift", d, img_read(4 + off, sz));
            end
        end
        // R7 read sweep over every lane offset and width.
        for (int off = 0; off < 8; off++)
            for (int sz = 0; sz < 4; sz++) begin
                rd(off, sz, d); check("R7 image read", d, img_read(off, sz));
            end
        // R6 lanes 1 and 3 ignore writes.
        wr(0, 2, 32'hFF0A_FF00);
        rd(0, 2, d); check("R6 holes stay zero", d, 32'h0);

        // R1/R2/R3/R4 command sweep with the engine idle.
        s_m = 0;
        for (int v = 0; v < 256; v++) begin
            logic [7:0] vb;
            vb = v[7:0];
            exp_st = vb[0] && !s_m && !act_m;
            exp_ab = !vb[0] && s_m && act_m;
            wr(0, 0, {24'h0, vb});
            if (vb[0] != s_m) act_m = vb[0];
            s_m = vb[0];
            cmd_m = vb & 8'h09;
            stat_m = {5'b0, 1'b0, 1'b0, act_m};
            check("R2 start pulse", saw_start, exp_st);
            check("R3 abort pulse", saw_abort, exp_ab);
            rd(0, 0, d); check("R4 cmd readback", d, {24'h0, cmd_m});
            check("R4 dir", dir, vb[3]);
            check("R1 active", active, act_m);
            if (exp_st) check("R2 pointer reload", cur_ptr, base_m);
        end

        // Now start=1 active=1. R1 same value again.
        wr(0, 0, 32'h1);
        check("R1 repeat start no pulse", saw_start, 0);
        check("R1 repeat start active", active, 1);

        // R3 stop while busy, then restart while pending.
        @(negedge clk); eng_busy = 1'b1;
        wr(0, 0, 32'h0);
        check("R3 no abort while busy", saw_abort, 0);
        repeat (3) @(negedge clk);
        check("R3 active held busy", active, 1);
        wr(4, 2, 32'h1234_5678); base_m = 32'h1234_5678;
        wr(0, 0, 32'h1);
        check("R2 no start when active", saw_start, 0);
        check("R2 reload when active", cur_ptr, base_m);
        @(negedge clk); eng_busy = 1'b0;
        repeat (2) @(negedge clk);
        check("R3 cancelled stop keeps active", active, 1);
        @(negedge clk); eng_busy = 1'b1;
        wr(0, 0, 32'h0);
        @(negedge clk); eng_busy = 1'b0;
        @(posedge clk); #1;
        check("R3 abort after drain", eng_abort, 1);
        check("R3 active cleared after drain", active, 0);

        // R9 completion.
        wr(0, 0, 32'h1);
        check("R2 start from idle", saw_start, 1);
        pulse_done(1'b1);
        check("R9 done with more keeps active", active, 1);
        pulse_done(1'b0);
        check("R9 last done clears active", active, 0);
        wr(0, 0, 32'h0);
        check("R3 stop when idle no abort", saw_abort, 0);

        // R5 interrupt.
        @(negedge clk); dev_irq = 1'b1; #1;
        check("R5 passthrough high", irq_out, 1);
        rd(2, 0, d); check("R5 rise sets status", d[2], 1);
        wr(2, 0, 32'h4);
        rd(2, 0, d); check("R5 w1c while high", d[2], 0);
        @(negedge clk); dev_irq = 1'b0; #1;
        check("R5 passthrough low", irq_out, 0);
        rd(2, 0, d); check("R5 low no set", d[2], 0);
        @(negedge clk); dev_irq = 1'b1;
        @(negedge clk); dev_irq = 1'b0;
        rd(2, 0, d); check("R5 low keeps status", d[2], 1);
        wr(2, 0, 32'h0);
        rd(2, 0, d); check("R5 write 0 keeps status", d[2], 1);
        wr(0, 0, 32'h1);
        wr(2, 0, 32'hFF);
        rd(2, 0, d); check("R5 active read-only", d, 32'h1);

        // R8 reset mid operation.
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R8 reset active", active, 0);
        check("R8 reset pointer", cur_ptr, 0);
        rd(0, 2, d); check("R8 reset regs", d, 0);
        rd(4, 2, d); check("R8 reset base", d, 0);
        @(negedge clk); rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule